// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the general-purpose register file of an 8-bit CPU. It holds an 8-bit accumulator A and a flags register F, plus three 16-bit register pairs, BC, DE and HL. HL can also serve as a 16-bit accumulator. Every one of these registers has an alternate copy.

Two exchange strobes choose which copy is visible. One strobe swaps A and F with their alternates. The other swaps BC, DE and HL with their alternates as a group. Each swap completes in one clock. No data moves during a swap: each of the two register groups has one bank-select bit, and the swap flips that bit.

The CPU datapath reads registers combinationally. It can read them through several byte-wide read ports and several pair-wide read ports, and all ports always see the bank that is currently selected. There is a single write port. It writes either one byte register or one full pair in a clock, and the write goes to the bank that is selected when the clock edge arrives.

Top module: `regx_file`

## Requirements
- R1: After reset, every register in both banks reads zero and both bank selects point at the primary bank, so a swap right after reset also shows zeros.
- R2: A byte read port returns the selected register of the active bank. The byte code is A=0, F=1, B=2, C=3, D=4, E=5, H=6, L=7.
- R3: A pair read port returns the high register in bits [15:8] and the low register in bits [7:0]. The pair code is AF=0, BC=1, DE=2, HL=3, where the high register is A, B, D or H.
- R4: A byte write (wr_en=1, wr_wide=0) stores wr_data[7:0] into the register coded by wr_sel in the active bank. It changes no other register in either bank.
- R5: A pair write (wr_en=1, wr_wide=1) stores wr_data[15:8] into the high register and wr_data[7:0] into the low register of the pair coded by wr_sel[1:0], in the active bank. wr_sel[2] is ignored.
- R6: A pulse on ex_af swaps the visible A and F with their alternates from the next cycle on. B, C, D, E, H and L are left unchanged.
- R7: A pulse on ex_regs swaps the visible BC, DE and HL with their alternates together from the next cycle on. A and F are left unchanged.
- R8: The contents of the inactive bank are kept unchanged, so two swaps of the same group restore the original view.
- R9: A write in the same cycle as a swap of its group lands in the bank that was active before that swap.
- R10: Pulses on ex_af and ex_regs in the same cycle perform both swaps.
- R11: All read ports work independently and at the same time, each with its own select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ex_af | input | 1 | Swap A/F with their alternates |
| ex_regs | input | 1 | Swap BC/DE/HL with their alternates |
| wr_en | input | 1 | Write enable |
| wr_wide | input | 1 | 1: pair write, 0: byte write |
| wr_sel | input | 3 | Byte code, or pair code in bits [1:0] |
| wr_data | input | 16 | Write data (byte writes use [7:0]) |
| rd8_sel | input | NUM_RD8*3 | Byte read selects, 3 bits per port |
| rd8_data | output | NUM_RD8*8 | Byte read data, 8 bits per port |
| rd16_sel | input | NUM_RD16*2 | Pair read selects, 2 bits per port |
| rd16_data | output | NUM_RD16*16 | Pair read data, 16 bits per port |

## Verification
The bench aims at these cases:
- A write that arrives in the same cycle as a swap. A design that swaps first would store the value in the newly active bank.
- Simultaneous swaps of both groups, and a swap of one group while the other group is written. A design with one shared select bit, or with a swap that crosses into the wrong group, shows foreign values in A/F or in the pairs.
- Pair writes with wr_sel[2] set, and reads through two ports at once. These expose byte-order or decode mistakes.
- Reads of the alternate bank after writes to the active one. These expose a swap that copies or corrupts data.

The bench keeps its own reference model, in which swaps really exchange the data. It compares every register on every read port after each cycle.

// File: rtl/regx_pkg.sv
package regx_pkg;
  localparam int REG_W  = 8;
  localparam int NREG   = 8;
  localparam int IDX_W  = 3;
  localparam int PAIR_W = 2;
  localparam int NSLOT  = 2 * NREG;
  localparam int SLOT_W = IDX_W + 1;

  // High register of a pair: codes 0,2,4,6
  function automatic logic [IDX_W-1:0] pair_hi(input logic [PAIR_W-1:0] p);
    return {p, 1'b0};
  endfunction

  // Low register of a pair: codes 1,3,5,7
  function automatic logic [IDX_W-1:0] pair_lo(input logic [PAIR_W-1:0] p);
    return {p, 1'b1};
  endfunction

  // A and F belong to the accumulator/flag group
  function automatic logic is_af(input logic [IDX_W-1:0] idx);
    return idx[IDX_W-1:1] == '0;
  endfunction

  // Physical storage slot: bank bit on top, register code below
  function automatic logic [SLOT_W-1:0] phys_slot(input logic [IDX_W-1:0] idx,
                                                  input logic af_b,
                                                  input logic grp_b);
    return {(is_af(idx) ? af_b : grp_b), idx};
  endfunction
endpackage

// File: rtl/regx_bank_toggle.sv
module regx_bank_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_af,
  input  logic ex_regs,
  output logic af_bank,
  output logic grp_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_bank  <= 1'b0;
      grp_bank <= 1'b0;
    end else begin
      if (ex_af)   af_bank  <= ~af_bank;
      if (ex_regs) grp_bank <= ~grp_bank;
    end
  end

  assert_af_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_af |=> af_bank != $past(af_bank));
  assert_af_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_af |=> $stable(af_bank));
  assert_grp_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ex_regs |=> grp_bank != $past(grp_bank));
  assert_grp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_regs |=> $stable(grp_bank));
endmodule

// File: rtl/regx_storage.sv
module regx_storage
  import regx_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              af_bank,
  input  logic                              grp_bank,
  input  logic                              wr_en,
  input  logic                              wr_wide,
  input  logic [IDX_W-1:0]                  wr_sel,
  input  logic [2*REG_W-1:0]                wr_data,
  output logic [NSLOT-1:0][REG_W-1:0]       slot_q
);
  logic [NSLOT-1:0]             slot_we;
  logic [NSLOT-1:0][REG_W-1:0]  slot_wd;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [IDX_W-1:0] IDX  = IDX_W'(s % NREG);
    localparam logic             BANK = 1'(s / NREG);
    logic owner_bank, hit_byte, hit_hi, hit_lo;

    always_comb begin
      owner_bank = is_af(IDX) ? af_bank : grp_bank;
      hit_byte   = wr_en && !wr_wide && (wr_sel == IDX);
      hit_hi     = wr_en &&  wr_wide && (pair_hi(wr_sel[PAIR_W-1:0]) == IDX);
      hit_lo     = wr_en &&  wr_wide && (pair_lo(wr_sel[PAIR_W-1:0]) == IDX);
      slot_we[s] = (owner_bank == BANK) && (hit_byte || hit_hi || hit_lo);
      slot_wd[s] = hit_hi ? wr_data[2*REG_W-1:REG_W] : wr_data[REG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[s] <= '0;
      else if (slot_we[s]) slot_q[s] <= slot_wd[s];
    end

    assert_slot_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_we[s] |=> $stable(slot_q[s]));
    assert_slot_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_we[s] |=> slot_q[s] == $past(slot_wd[s]));
  end

  assert_write_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_we) <= (wr_wide ? 2 : 1));
  assert_no_idle_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> slot_we == '0);
endmodule

// File: rtl/regx_read_mux.sv
module regx_read_mux
  import regx_pkg::*;
#(
  parameter int NUM_RD8  = 2,
  parameter int NUM_RD16 = 2
) (
  input  logic [NSLOT-1:0][REG_W-1:0]       slot_q,
  input  logic                              af_bank,
  input  logic                              grp_bank,
  input  logic [NUM_RD8*IDX_W-1:0]          rd8_sel,
  output logic [NUM_RD8*REG_W-1:0]          rd8_data,
  input  logic [NUM_RD16*PAIR_W-1:0]        rd16_sel,
  output logic [NUM_RD16*2*REG_W-1:0]       rd16_data
);
  for (genvar p = 0; p < NUM_RD8; p++) begin : g_rd8
    logic [IDX_W-1:0] sel;
    always_comb begin
      sel = rd8_sel[p*IDX_W +: IDX_W];
      rd8_data[p*REG_W +: REG_W] = slot_q[phys_slot(sel, af_bank, grp_bank)];
    end
  end

  for (genvar p = 0; p < NUM_RD16; p++) begin : g_rd16
    logic [PAIR_W-1:0] psel;
    always_comb begin
      psel = rd16_sel[p*PAIR_W +: PAIR_W];
      rd16_data[p*2*REG_W +: 2*REG_W] =
        {slot_q[phys_slot(pair_hi(psel), af_bank, grp_bank)],
         slot_q[phys_slot(pair_lo(psel), af_bank, grp_bank)]};
    end
  end
endmodule

// File: rtl/regx_file.sv
module regx_file
  import regx_pkg::*;
#(
  parameter int NUM_RD8  = 2,
  parameter int NUM_RD16 = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ex_af,
  input  logic                          ex_regs,
  input  logic                          wr_en,
  input  logic                          wr_wide,
  input  logic [2:0]                    wr_sel,
  input  logic [15:0]                   wr_data,
  input  logic [NUM_RD8*3-1:0]          rd8_sel,
  output logic [NUM_RD8*8-1:0]          rd8_data,
  input  logic [NUM_RD16*2-1:0]         rd16_sel,
  output logic [NUM_RD16*16-1:0]        rd16_data
);
  logic                         af_bank;
  logic                         grp_bank;
  logic [NSLOT-1:0][REG_W-1:0]  slot_q;

  regx_bank_toggle u_toggle (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_af    (ex_af),
    .ex_regs  (ex_regs),
    .af_bank  (af_bank),
    .grp_bank (grp_bank)
  );

  regx_storage u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .af_bank  (af_bank),
    .grp_bank (grp_bank),
    .wr_en    (wr_en),
    .wr_wide  (wr_wide),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .slot_q   (slot_q)
  );

  regx_read_mux #(.NUM_RD8(NUM_RD8), .NUM_RD16(NUM_RD16)) u_rd (
    .slot_q    (slot_q),
    .af_bank   (af_bank),
    .grp_bank  (grp_bank),
    .rd8_sel   (rd8_sel),
    .rd8_data  (rd8_data),
    .rd16_sel  (rd16_sel),
    .rd16_data (rd16_data)
  );

  // A byte write to A with no swap is visible on port 0 reading A next cycle
  assert_a_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_wide && wr_sel == 3'd0 && !ex_af && rd8_sel[2:0] == 3'd0)
      |=> (rd8_sel[2:0] != 3'd0) || (rd8_data[7:0] == $past(wr_data[7:0])));
endmodule

// File: tb/regx_file_bench.sv
module regx_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ex_af = 1'b0, ex_regs = 1'b0, wr_en = 1'b0, wr_wide = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  rd8_sel = '0;
  logic [15:0] rd8_data;
  logic [3:0]  rd16_sel = '0;
  logic [31:0] rd16_data;

  int checks = 0;
  int failures = 0;

  // Reference: visible and hidden copies; swaps really move the data
  logic [7:0] cur [8];
  logic [7:0] alt [8];

  always #10 clk = ~clk;

  regx_file u_regx_file (
    .clk(clk), .rst_n(rst_n), .ex_af(ex_af), .ex_regs(ex_regs),
    .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd8_sel(rd8_sel), .rd8_data(rd8_data),
    .rd16_sel(rd16_sel), .rd16_data(rd16_data)
  );

  function automatic logic [15:0] ref_pair(input int p);
    return {cur[2*p], cur[2*p+1]};
  endfunction

  task automatic model_step(input logic xa, input logic xr, input logic we,
                            input logic wide, input logic [2:0] sel,
                            input logic [15:0] d);
    logic [7:0] t;
    if (we) begin
      if (wide) begin
        cur[{sel[1:0], 1'b0}] = d[15:8];
        cur[{sel[1:0], 1'b1}] = d[7:0];
      end else cur[sel] = d[7:0];
    end
    for (int i = 0; i < 8; i++) begin
      if ((i < 2 && xa) || (i >= 2 && xr)) begin
        t = cur[i]; cur[i] = alt[i]; alt[i] = t;
      end
    end
  endtask

  task automatic do_cycle(input logic xa, input logic xr, input logic we,
                          input logic wide, input logic [2:0] sel,
                          input logic [15:0] d);
    @(negedge clk);
    ex_af = xa; ex_regs = xr; wr_en = we; wr_wide = wide; wr_sel = sel; wr_data = d;
    @(posedge clk);
    model_step(xa, xr, we, wide, sel, d);
    #1;
    ex_af = 0; ex_regs = 0; wr_en = 0; wr_wide = 0;
  endtask

  // Sweeps all registers and pairs on both ports of each kind (R2, R3, R11)
  task automatic check_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd8_sel = {3'(7 - i), 3'(i)};
      #1;
      checks++;
      if (rd8_data[7:0] !== cur[i] || rd8_data[15:8] !== cur[7-i]) begin
        failures++;
        $display("FAIL %s R2/R11 reg %0d got %h/%h exp %h/%h", tag, i,
                 rd8_data[7:0], rd8_data[15:8], cur[i], cur[7-i]);
      end
    end
    for (int p = 0; p < 4; p++) begin
      rd16_sel = {2'(3 - p), 2'(p)};
      #1;
      checks++;
      if (rd16_data[15:0] !== ref_pair(p) || rd16_data[31:16] !== ref_pair(3 - p)) begin
        failures++;
        $display("FAIL %s R3/R11 pair %0d got %h/%h exp %h/%h", tag, p,
                 rd16_data[15:0], rd16_data[31:16], ref_pair(p), ref_pair(3 - p));
      end
    end
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin cur[i] = '0; alt[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 primary");
    do_cycle(1, 1, 0, 0, 0, 0);
    check_all("R1 alternate");
    do_cycle(1, 1, 0, 0, 0, 0);
    // R4 byte writes, R5 pair writes with wr_sel[2] set
    do_cycle(0, 0, 1, 0, 3'd0, 16'h0011);
    do_cycle(0, 0, 1, 0, 3'd1, 16'h0022);
    do_cycle(0, 0, 1, 1, 3'd5, 16'h3344);
    do_cycle(0, 0, 1, 1, 3'd2, 16'h5566);
    do_cycle(0, 0, 1, 1, 3'd7, 16'h7788);
    check_all("R4 R5 writes");
    // R6 AF swap only
    do_cycle(1, 0, 0, 0, 0, 0);
    check_all("R6 af swap");
    do_cycle(0, 0, 1, 0, 3'd0, 16'h00a1);
    do_cycle(1, 0, 0, 0, 0, 0);
    check_all("R8 af restore");
    // R7 group swap
    do_cycle(0, 1, 0, 0, 0, 0);
    check_all("R7 grp swap");
    do_cycle(0, 1, 1, 1, 3'd3, 16'hbeef);
    check_all("R9 write with grp swap");
    do_cycle(1, 0, 1, 0, 3'd1, 16'h00c3);
    check_all("R9 write with af swap");
    do_cycle(1, 1, 1, 1, 3'd0, 16'hd00d);
    check_all("R10 both swaps");
    do_cycle(0, 1, 0, 0, 0, 0);
    check_all("R8 grp restore");
    // Random mix
    for (int n = 0; n < 400; n++) begin
      do_cycle(($urandom % 5) == 0, ($urandom % 5) == 0, ($urandom % 3) != 0,
               1'($urandom), 3'($urandom), 16'($urandom));
      check_all("R4-mix random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule